// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This core encrypts a single 128-bit block with AES-128. It reuses one round datapath over ten clock cycles. The caller provides the plaintext, the full set of eleven 128-bit round keys (already expanded) and a one-cycle start pulse while the core is idle.

The first key is XORed into the block in the same cycle that start is sampled. Each of the next ten cycles then performs one complete round: byte substitution, row rotation, column mixing and round-key XOR. The tenth round drops the column mixing. A one-cycle done pulse marks the ciphertext as valid, and the ciphertext output holds that value until a new block is accepted.

The core is intended for single-block electronic-codebook use. The surrounding logic owns key expansion and any chaining.

Top module: `aes_enc_core`

## Requirements
- R1: While reset is asserted, and after a reset taken during a run, `done_o` is 0 and `cipher_o` is all zeros.
- R2: For the standard AES-128 test vectors, `cipher_o` equals the published ciphertext when the properly expanded key schedule is supplied. The vectors are key 2b7e1516..., key 00010203... and the all-zero key with a zero block.
- R3: Round keys are used exactly as given, with no assumption that they form a real schedule:
  - key 0 is XORed into the block before round 1;
  - rounds 1 to 9 perform substitution, rotation, mixing and an XOR with key r;
  - round 10 performs substitution and rotation, then an XOR with key 10, with no mixing.
- R4: Byte k of a block sits at bits [127-8k -: 8], where byte 0 is the most significant byte. The state is column-major: byte k is at row k mod 4, column k div 4. Round key r occupies `rkeys_i[128*r +: 128]` with the same byte order.
- R5: The done pulse is high for exactly one cycle, at the tenth rising edge after the edge that accepted start.
- R6: While the core is idle and no start is given, `cipher_o` does not change.
- R7: A start pulse, or a change on `plain_i`, while a block is in progress has no effect on that block's result or done timing, and does not start a further block.
- R8: A start given in the cycle where `done_o` is high is accepted, so blocks can run back to back with ten cycles per block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, sampled only when idle |
| plain_i | input | 128 | Plaintext block, byte 0 in the top bits |
| rkeys_i | input | 1408 | Round keys 0..10, key r at bits [128r +: 128] |
| cipher_o | output | 128 | Ciphertext, held until the next accepted start |
| done_o | output | 1 | One-cycle pulse when the ciphertext is valid |

## Verification
The bench builds the core with its default of ten rounds. This is the only setting for which published ciphertexts exist, and it is the setting that drives the round counter and key select all the way to key 10, where mixing is bypassed. The bench has its own key expansion and round model, so it can feed key sets that are not valid schedules and single-byte plaintexts. Those inputs isolate the skipped final mixing and the column-major byte mapping. The bench also places start pulses in the first cycles of a run, in the last-round cycle and in the done cycle, which exercises the idle-only accept rule at both of its edges.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W     = 128;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int ROWS      = 4;
  localparam int COLS      = BLK_BYTES / ROWS;

  // Multiply by {02} in GF(2^8) with the AES reduction polynomial.
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // Field inverse as a^254, built from successive squarings.
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] res;
    pw  = a;
    res = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw  = gf_mul(pw, pw);
      res = gf_mul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // Builds the substitution table at elaboration time: entry x at bits [8x +: 8].
  function automatic logic [2047:0] sbox_table();
    logic [2047:0] tbl;
    logic [7:0]    inv;
    tbl = '0;
    for (int x = 0; x < 256; x++) begin
      inv = gf_inv(8'(x));
      tbl[8*x +: 8] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                      ^ rotl8(inv, 4) ^ 8'h63;
    end
    return tbl;
  endfunction

  localparam logic [2047:0] SBOX_TABLE = sbox_table();

endpackage

// File: rtl/aes_enc_sbox.sv
module aes_enc_sbox
  import aes_enc_pkg::*;
(
  input  logic [7:0] in_b,
  output logic [7:0] out_b
);

  // High nibble picks the row and low nibble the column of the 16x16 table.
  logic [3:0] row_sel;
  logic [3:0] col_sel;

  assign row_sel = in_b[7:4];
  assign col_sel = in_b[3:0];
  assign out_b   = SBOX_TABLE[8*{row_sel, col_sel} +: 8];

endmodule

// File: rtl/aes_enc_mixcol.sv
module aes_enc_mixcol
  import aes_enc_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);

  logic [7:0] a0, a1, a2, a3;
  logic [7:0] d0, d1, d2, d3;

  assign {a0, a1, a2, a3} = col_i;

  // Doubled copies; tripling is double XOR original.
  assign d0 = xtime(a0);
  assign d1 = xtime(a1);
  assign d2 = xtime(a2);
  assign d3 = xtime(a3);

  assign col_o[31:24] = d0 ^ (d1 ^ a1) ^ a2 ^ a3;
  assign col_o[23:16] = a0 ^ d1 ^ (d2 ^ a2) ^ a3;
  assign col_o[15:8]  = a0 ^ a1 ^ d2 ^ (d3 ^ a3);
  assign col_o[7:0]   = (d0 ^ a0) ^ a1 ^ a2 ^ d3;

endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  input  logic [BLK_W-1:0] rk_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] st_o
);

  logic [7:0]  sub_b [BLK_BYTES];
  logic [7:0]  shf_b [BLK_BYTES];
  logic [7:0]  mix_b [BLK_BYTES];

  // Byte substitution, one table per state byte.
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_sub
    aes_enc_sbox sbox_i (
      .in_b  (st_i[BLK_W-1-8*k -: 8]),
      .out_b (sub_b[k])
    );
  end

  // Row r rotates left by r columns; byte index is row + 4*column.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign shf_b[r + ROWS*c] = sub_b[r + ROWS*((c + r) % COLS)];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_mix
    logic [31:0] col_out;
    aes_enc_mixcol mixcol_i (
      .col_i ({shf_b[ROWS*c], shf_b[ROWS*c+1], shf_b[ROWS*c+2], shf_b[ROWS*c+3]}),
      .col_o (col_out)
    );
    assign mix_b[ROWS*c]   = col_out[31:24];
    assign mix_b[ROWS*c+1] = col_out[23:16];
    assign mix_b[ROWS*c+2] = col_out[15:8];
    assign mix_b[ROWS*c+3] = col_out[7:0];
  end

  // Final round bypasses mixing; every round ends with the key XOR.
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_ark
    assign st_o[BLK_W-1-8*k -: 8] = (last_i ? shf_b[k] : mix_b[k])
                                    ^ rk_i[BLK_W-1-8*k -: 8];
  end

endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl #(
  parameter int NR = 10,
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          last_o,
  output logic [CW-1:0] rnd_o,
  output logic          done_o
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_t;

  ctrl_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign busy_o   = (st_q == ST_RUN);
  assign last_o   = busy_o && (cnt_q == CW'(NR));
  assign rnd_o    = cnt_q;
  assign done_o   = done_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_RUN;
          cnt_d  = CW'(1);
          cnt_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (cnt_q == CW'(NR)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/aes_enc_rst_sync.sv
module aes_enc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/aes_enc_core.sv
module aes_enc_core
  import aes_enc_pkg::*;
#(
  parameter int NR = 10,
  localparam int KEYS_W = (NR + 1) * BLK_W,
  localparam int CW     = $clog2(NR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  plain_i,
  input  logic [KEYS_W-1:0] rkeys_i,
  output logic [BLK_W-1:0]  cipher_o,
  output logic              done_o
);

  logic             rst_q;
  logic             accept;
  logic             busy;
  logic             last;
  logic [CW-1:0]    rnd;
  logic [BLK_W-1:0] rk_arr [NR+1];
  logic [BLK_W-1:0] round_key;
  logic [BLK_W-1:0] round_out;
  logic [BLK_W-1:0] state_q, state_d;
  logic             state_en;

  aes_enc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  aes_enc_ctrl #(.NR(NR)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .rnd_o    (rnd),
    .done_o   (done_o)
  );

  for (genvar r = 0; r <= NR; r++) begin : g_keys
    assign rk_arr[r] = rkeys_i[BLK_W*r +: BLK_W];
  end

  assign round_key = rk_arr[rnd];

  aes_enc_round round_i (
    .st_i   (state_q),
    .rk_i   (round_key),
    .last_i (last),
    .st_o   (round_out)
  );

  always_comb begin
    state_en = 1'b0;
    state_d  = state_q;
    if (accept) begin
      state_en = 1'b1;
      state_d  = plain_i ^ rk_arr[0];
    end else if (busy) begin
      state_en = 1'b1;
      state_d  = round_out;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign cipher_o = state_q;

endmodule

// File: rtl/aes_enc_core_chk.sv
module aes_enc_core_chk #(
  parameter int NR = 10,
  localparam int CW = $clog2(NR + 1)
) (
  input logic         clk,
  input logic         rst_q,
  input logic         start_i,
  input logic         busy,
  input logic         done_o,
  input logic [127:0] cipher_o
);

  // Independent count of edges since the accepted start.
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cyc_q <= '0;
    end else if (start_i && !busy) begin
      cyc_q <= CW'(1);
    end else if (cyc_q != '0) begin
      cyc_q <= (cyc_q == CW'(NR)) ? '0 : cyc_q + CW'(1);
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> !busy);

  // R7
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> $past(cyc_q == CW'(NR)));

  // R5
  done_due_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cyc_q == CW'(NR)) |=> done_o);

  // R6
  cipher_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && !start_i) |=> $stable(cipher_o));

endmodule

bind aes_enc_core aes_enc_core_chk #(.NR(NR)) chk_i (
  .clk      (clk),
  .rst_q    (rst_q),
  .start_i  (start_i),
  .busy     (busy),
  .done_o   (done_o),
  .cipher_o (cipher_o)
);

// File: tb/aes_enc_core_tb_top.sv
module aes_enc_core_tb_top;

  localparam int NR     = 10;
  localparam int KEYS_W = (NR + 1) * 128;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [127:0]      plain_i;
  logic [KEYS_W-1:0] rkeys_i;
  logic [127:0]      cipher_o;
  logic              done_o;

  int checks;
  int errors;

  logic [7:0] sb_ref [256];

  aes_enc_core #(.NR(NR)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .plain_i  (plain_i),
    .rkeys_i  (rkeys_i),
    .cipher_o (cipher_o),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- reference model ----------------
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    logic [7:0] y;
    p = 0; x = a; y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox_ref();
    logic [7:0] inv;
    logic [7:0] s;
    for (int v = 0; v < 256; v++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (v != 0 && ref_mul(8'(v), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
               ^ inv[(i+7)%8] ^ (((8'h63 >> i) & 8'h01) != 0);
      sb_ref[v] = s;
    end
  endtask

  function automatic logic [KEYS_W-1:0] ref_expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    logic [KEYS_W-1:0] out;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb_ref[t[31:24]], sb_ref[t[23:16]], sb_ref[t[15:8]], sb_ref[t[7:0]]};
        t[31:24] ^= rc;
        rc = ref_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++)
      out[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return out;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [KEYS_W-1:0] rks);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ rks[127-8*k -: 8];
    for (int r = 1; r <= NR; r++) begin
      for (int k = 0; k < 16; k++) t[k] = sb_ref[s[k]];
      for (int row = 0; row < 4; row++)
        for (int c = 0; c < 4; c++) s[row+4*c] = t[row+4*((c+row)%4)];
      if (r != NR) begin
        for (int c = 0; c < 4; c++) begin
          t[4*c]   = ref_mul(s[4*c],8'h02) ^ ref_mul(s[4*c+1],8'h03) ^ s[4*c+2] ^ s[4*c+3];
          t[4*c+1] = s[4*c] ^ ref_mul(s[4*c+1],8'h02) ^ ref_mul(s[4*c+2],8'h03) ^ s[4*c+3];
          t[4*c+2] = s[4*c] ^ s[4*c+1] ^ ref_mul(s[4*c+2],8'h02) ^ ref_mul(s[4*c+3],8'h03);
          t[4*c+3] = ref_mul(s[4*c],8'h03) ^ s[4*c+1] ^ s[4*c+2] ^ ref_mul(s[4*c+3],8'h02);
        end
        for (int k = 0; k < 16; k++) s[k] = t[k];
      end
      for (int k = 0; k < 16; k++) s[k] ^= rks[128*r + 127 - 8*k -: 8];
    end
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = s[k];
    return o;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Starts at a negedge; returns at the negedge where done_o is seen.
  task automatic run_block(input logic [127:0] pt, input logic [KEYS_W-1:0] rks,
                           output logic [127:0] ct, output int lat);
    plain_i = pt;
    rkeys_i = rks;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done_o && lat < 40);
    ct = cipher_o;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    plain_i = '0;
    rkeys_i = '0;
    repeat (3) @(negedge clk);
    // R1
    check(done_o == 1'b0, "R1", "done in reset", 128'(done_o), 128'd0);
    check(cipher_o == '0, "R1", "cipher in reset", cipher_o, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_vectors();
    logic [127:0] ct;
    int lat;
    run_block(128'h3243f6a8885a308d313198a2e0370734,
              ref_expand(128'h2b7e151628aed2a6abf7158809cf4f3c), ct, lat);
    check(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R2", "vector key 2b7e",
          ct, 128'h3925841d02dc09fbdc118597196a0b32);
    // R5
    check(lat == NR, "R5", "done latency", 128'(lat), 128'(NR));
    @(negedge clk);
    check(done_o == 1'b0, "R5", "done width", 128'(done_o), 128'd0);
    run_block(128'h00112233445566778899aabbccddeeff,
              ref_expand(128'h000102030405060708090a0b0c0d0e0f), ct, lat);
    check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2", "vector key 0001",
          ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    @(negedge clk);
    run_block('0, ref_expand('0), ct, lat);
    check(ct == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2", "zero vector",
          ct, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    @(negedge clk);
  endtask

  task automatic test_free_keys();
    logic [KEYS_W-1:0] rks;
    logic [127:0] pt;
    logic [127:0] ct;
    logic [127:0] exp;
    int lat;
    for (int r = 0; r <= NR; r++)
      rks[128*r +: 128] = {4{32'h9e3779b9 * 32'(r + 1)}} ^ {16{8'(r * 29)}};
    pt  = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;
    exp = ref_enc(pt, rks);
    run_block(pt, rks, ct, lat);
    // R3
    check(ct == exp, "R3", "arbitrary round keys", ct, exp);
    @(negedge clk);
    rks = '0;
    rks[128*NR +: 128] = 128'h0123456789abcdeffedcba9876543210;
    exp = ref_enc('0, rks);
    run_block('0, rks, ct, lat);
    check(ct == exp, "R3", "only last key set", ct, exp);
    @(negedge clk);
  endtask

  task automatic test_byte_map();
    logic [127:0] ct;
    logic [127:0] exp;
    int lat;
    exp = ref_enc({8'h01, 120'h0}, '0);
    run_block({8'h01, 120'h0}, '0, ct, lat);
    // R4
    check(ct == exp, "R4", "byte 0 set", ct, exp);
    @(negedge clk);
    exp = ref_enc({32'h0, 8'h01, 88'h0}, '0);
    run_block({32'h0, 8'h01, 88'h0}, '0, ct, lat);
    check(ct == exp, "R4", "byte 4 set", ct, exp);
    @(negedge clk);
  endtask

  task automatic test_hold();
    logic [127:0] ct;
    int lat;
    bit stable;
    run_block(128'h1111222233334444aaaabbbbccccdddd, ref_expand(128'h5555), ct, lat);
    stable = 1'b1;
    for (int i = 0; i < 6; i++) begin
      plain_i = plain_i ^ 128'hffff;
      @(negedge clk);
      if (cipher_o != ct) stable = 1'b0;
    end
    // R6
    check(stable, "R6", "cipher held while idle", cipher_o, ct);
  endtask

  task automatic test_busy_start();
    logic [KEYS_W-1:0] rks;
    logic [127:0] pt;
    logic [127:0] exp;
    int lat;
    bit quiet;
    rks = ref_expand(128'hcafef00d);
    pt  = 128'h0badc0de0badc0de0badc0de0badc0de;
    exp = ref_enc(pt, rks);
    plain_i = pt;
    rkeys_i = rks;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_i = (lat == 3) || (lat == 9);
      if (lat == 3) plain_i = ~pt;
    end while (!done_o && lat < 40);
    start_i = 1'b0;
    // R7
    check(lat == NR, "R7", "latency with busy starts", 128'(lat), 128'(NR));
    check(cipher_o == exp, "R7", "result with busy starts", cipher_o, exp);
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done_o || cipher_o != exp) quiet = 1'b0;
    end
    check(quiet, "R7", "no extra block started", cipher_o, exp);
  endtask

  task automatic test_back_to_back();
    logic [127:0] ct;
    logic [127:0] exp;
    int lat;
    run_block(128'h1, ref_expand(128'h2), ct, lat);
    exp = ref_enc(128'h3, ref_expand(128'h4));
    run_block(128'h3, ref_expand(128'h4), ct, lat);
    // R8
    check(lat == NR, "R8", "back-to-back latency", 128'(lat), 128'(NR));
    check(ct == exp, "R8", "back-to-back result", ct, exp);
    @(negedge clk);
  endtask

  task automatic test_reset_midrun();
    plain_i = 128'h77;
    rkeys_i = ref_expand(128'h88);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R1
    check(done_o == 1'b0 && cipher_o == '0, "R1", "reset mid-run", cipher_o, 128'd0);
    rst_n = 1'b1;
    repeat (14) @(negedge clk);
    check(done_o == 1'b0 && cipher_o == '0, "R1", "no result after reset", cipher_o, 128'd0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    build_sbox_ref();
    do_reset();
    test_vectors();
    test_free_keys();
    test_byte_map();
    test_hold();
    test_busy_start();
    test_back_to_back();
    test_reset_midrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule